// File: doc/BRIEF.md
# CAN Controller Operating Mode Manager

This block holds the operating mode of a CAN controller and turns it into the control levels used by the rest of the controller. It chooses one of five modes: Configuration, Normal, Sleep, Loopback and Snoop. The choice comes from software request bits, and a frame seen on the bus can also change it. The resulting mode decides four things: whether the transmit path may start a frame, whether the bus pin follows the transmitter or is held recessive, what bit the receiver sees, and whether the error counters and timing registers are held in their configuration state.

Software writes an enable bit and three request bits. Changes between operational modes wait until the bus reports idle, so a frame already on the bus is never cut. Clearing the enable bit is the exception: it forces Configuration at the next clock edge. In Sleep, a start of frame from another node wakes the controller into Normal, and two sticky interrupt flags record sleep entry and bus wake-up.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset the mode is Configuration. `mode_status` is one-hot with bit 0 = Configuration, bit 1 = Normal, bit 2 = Sleep, bit 3 = Loopback and bit 4 = Snoop. Exactly one bit is set at all times.
- R2: In Configuration, `pin_tx` is recessive (1), both transmit grants are low, `core_rx_bit` is recessive whatever `pin_rx` does, and `err_cnt_clr` and `timing_wr_en` are high. Both of these outputs are low in every other mode.
- R3: The requested mode decodes as follows. Enable low requests Configuration. With enable high, the sleep request wins over loopback, loopback wins over snoop, and with none of them set the request is Normal.
- R4: A change to any mode other than Configuration, including leaving Configuration, happens at the first clock edge at which `bus_idle` is high. The mode holds while `bus_idle` is low.
- R5: Enable low puts the controller in Configuration at the next clock edge whatever `bus_idle` is, and it takes precedence over a wake-up from Sleep (no wake flag is set).
- R6: In Normal, `pin_tx` follows `core_tx_bit`, `core_rx_bit` follows `pin_rx`, and the transmit grants follow the pending flags.
- R7: When the high-priority buffer and the TX queue are both pending in a mode that allows transmission, only `grant_hpb` is high.
- R8: In Sleep, both grants stay low even with requests pending, `pin_tx` is recessive, and `core_rx_bit` follows `pin_rx`.
- R9: In Sleep, `rx_sof` high moves the mode to Normal at the next edge, even while `bus_idle` is low. After that wake-up the sleep request bit is ignored until software writes it low.
- R10: `irq_sleep` sets on entry to Sleep and `irq_wake` sets on a bus wake-up. Each flag stays set until a one-cycle pulse on its own clear input, which clears it at the next edge without touching the other flag.
- R11: In Loopback, `pin_tx` is recessive, `core_rx_bit` follows `core_tx_bit` and not `pin_rx`, `self_ack` is high, and transmit grants are allowed.
- R12: In Snoop, `pin_tx` is recessive, both grants are low, and `core_rx_bit` follows `pin_rx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Software enable; low requests Configuration |
| ctl_sleep_req | input | 1 | Sleep request bit |
| ctl_loop_req | input | 1 | Loopback request bit |
| ctl_snoop_req | input | 1 | Snoop request bit |
| bus_idle | input | 1 | Bus is between frames |
| rx_sof | input | 1 | Start of frame detected on the bus |
| txq_pending | input | 1 | TX queue holds a frame |
| hpb_pending | input | 1 | High-priority buffer holds a frame |
| irq_sleep_clr | input | 1 | Write-one-to-clear pulse for the sleep flag |
| irq_wake_clr | input | 1 | Write-one-to-clear pulse for the wake flag |
| core_tx_bit | input | 1 | Bit from the transmitter |
| pin_rx | input | 1 | Bus receive pin |
| pin_tx | output | 1 | Bus transmit pin |
| core_rx_bit | output | 1 | Bit presented to the receiver |
| self_ack | output | 1 | Receiver acknowledges its own frames |
| grant_hpb | output | 1 | High-priority buffer may start |
| grant_txq | output | 1 | TX queue may start |
| err_cnt_clr | output | 1 | Hold error counters and synchronisation in reset |
| timing_wr_en | output | 1 | Timing and prescaler registers writable |
| mode_status | output | 5 | One-hot current mode |
| irq_sleep | output | 1 | Sticky sleep-entry flag |
| irq_wake | output | 1 | Sticky wake-up flag |

## Verification
The hardest state to reach is the one right after a bus wake-up while the sleep request is still set. The controller must then stay out of Sleep, and pending loopback or snoop requests must be honoured only at idle. The stimulus raises all three request bits, enters Sleep, and wakes the controller with `rx_sof` while `bus_idle` is low. It then steps through idle cycles with the sleep bit still high, and lowers and raises that bit again. A second hard corner is a drop to Configuration on the same edge as a wake-up. The bench reaches it by entering Sleep from Configuration and then clearing the enable bit in the same cycle that `rx_sof` rises.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    localparam int NUM_MODES = 5;

    typedef enum logic [2:0] {
        MODE_CFG    = 3'd0,
        MODE_NORMAL = 3'd1,
        MODE_SLEEP  = 3'd2,
        MODE_LOOP   = 3'd3,
        MODE_SNOOP  = 3'd4
    } mode_e;

    typedef struct packed {
        logic enable;
        logic sleep;
        logic loopback;
        logic snoop;
    } mode_req_t;

    typedef struct packed {
        logic hpb;
        logic txq;
    } tx_pend_t;

    function automatic logic [NUM_MODES-1:0] mode_onehot(input mode_e m);
        logic [NUM_MODES-1:0] r;
        r = '0;
        r[m] = 1'b1;
        return r;
    endfunction

    function automatic logic mode_may_transmit(input mode_e m);
        return (m == MODE_NORMAL) || (m == MODE_LOOP);
    endfunction

endpackage

// File: rtl/can_mode_decode.sv
module can_mode_decode
    import can_mode_pkg::*;
(
    input  mode_req_t req,
    input  logic      sleep_block,
    output mode_e     target
);

    always_comb begin
        if (!req.enable)
            target = MODE_CFG;
        else if (req.sleep && !sleep_block)
            target = MODE_SLEEP;
        else if (req.loopback)
            target = MODE_LOOP;
        else if (req.snoop)
            target = MODE_SNOOP;
        else
            target = MODE_NORMAL;
    end

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e target,
    input  logic  sleep_req,
    input  logic  bus_idle,
    input  logic  rx_sof,
    output mode_e mode,
    output logic  sleep_block,
    output logic  enter_sleep,
    output logic  bus_wake
);

    mode_e mode_q, mode_d;
    logic  block_q;

    always_comb begin
        mode_d      = mode_q;
        bus_wake    = 1'b0;
        if (target == MODE_CFG) begin
            mode_d = MODE_CFG;
        end else if (mode_q == MODE_SLEEP && rx_sof) begin
            mode_d   = MODE_NORMAL;
            bus_wake = 1'b1;
        end else if (target != mode_q && bus_idle) begin
            mode_d = target;
        end
        enter_sleep = (mode_d == MODE_SLEEP) && (mode_q != MODE_SLEEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_CFG;
            block_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (bus_wake)
                block_q <= 1'b1;
            else if (!sleep_req)
                block_q <= 1'b0;
        end
    end

    assign mode        = mode_q;
    assign sleep_block = block_q;

    // R5
    cfg_immediate_chk: assert property (@(posedge clk) disable iff (rst)
        (target == MODE_CFG) |=> (mode_q == MODE_CFG));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (target != MODE_CFG && target != mode_q && !bus_idle &&
         !(mode_q == MODE_SLEEP && rx_sof)) |=> $stable(mode_q));

    // R9
    sof_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SLEEP && rx_sof && target != MODE_CFG) |=> (mode_q == MODE_NORMAL));

    // R9
    wake_block_chk: assert property (@(posedge clk) disable iff (rst)
        (block_q && sleep_req) |-> (target != MODE_SLEEP));

endmodule

// File: rtl/can_mode_paths.sv
module can_mode_paths
    import can_mode_pkg::*;
#(
    parameter logic RECESSIVE = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  mode_e    mode,
    input  tx_pend_t pend,
    input  logic     core_tx_bit,
    input  logic     pin_rx,
    output logic     pin_tx,
    output logic     core_rx_bit,
    output logic     self_ack,
    output logic     grant_hpb,
    output logic     grant_txq,
    output logic     err_cnt_clr,
    output logic     timing_wr_en
);

    logic tx_ok;

    always_comb begin
        pin_tx       = RECESSIVE;
        core_rx_bit  = pin_rx;
        self_ack     = 1'b0;
        err_cnt_clr  = 1'b0;
        timing_wr_en = 1'b0;
        tx_ok        = mode_may_transmit(mode);
        unique case (mode)
            MODE_CFG: begin
                core_rx_bit  = RECESSIVE;
                err_cnt_clr  = 1'b1;
                timing_wr_en = 1'b1;
            end
            MODE_NORMAL: pin_tx = core_tx_bit;
            MODE_SLEEP:  ;
            MODE_LOOP: begin
                core_rx_bit = core_tx_bit;
                self_ack    = 1'b1;
            end
            MODE_SNOOP:  ;
            default: begin
                core_rx_bit = RECESSIVE;
                tx_ok       = 1'b0;
            end
        endcase
        grant_hpb = tx_ok && pend.hpb;
        grant_txq = tx_ok && pend.txq && !pend.hpb;
    end

    // R2
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CFG) |-> (pin_tx == RECESSIVE && !grant_hpb && !grant_txq &&
                                core_rx_bit == RECESSIVE));

    // R8
    sleep_no_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLEEP) |-> (!grant_hpb && !grant_txq && pin_tx == RECESSIVE));

    // R12
    snoop_listen_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SNOOP) |-> (!grant_hpb && !grant_txq && core_rx_bit == pin_rx));

    // R7
    grant_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(grant_hpb && grant_txq));

endmodule

// File: rtl/can_mode_irq.sv
module can_mode_irq #(
    parameter int NUM_IRQ = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] set,
    input  logic [NUM_IRQ-1:0] clr,
    output logic [NUM_IRQ-1:0] flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= '0;
        end else begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (set[i])
                    flag[i] <= 1'b1;
                else if (clr[i])
                    flag[i] <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chk
        // R10
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (flag[g] && !clr[g]) |=> flag[g]);
        // R10
        set_take_chk: assert property (@(posedge clk) disable iff (rst)
            set[g] |=> flag[g]);
    end

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter logic RECESSIVE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_enable,
    input  logic                 ctl_sleep_req,
    input  logic                 ctl_loop_req,
    input  logic                 ctl_snoop_req,
    input  logic                 bus_idle,
    input  logic                 rx_sof,
    input  logic                 txq_pending,
    input  logic                 hpb_pending,
    input  logic                 irq_sleep_clr,
    input  logic                 irq_wake_clr,
    input  logic                 core_tx_bit,
    input  logic                 pin_rx,
    output logic                 pin_tx,
    output logic                 core_rx_bit,
    output logic                 self_ack,
    output logic                 grant_hpb,
    output logic                 grant_txq,
    output logic                 err_cnt_clr,
    output logic                 timing_wr_en,
    output logic [NUM_MODES-1:0] mode_status,
    output logic                 irq_sleep,
    output logic                 irq_wake
);

    localparam int IRQ_SLEEP = 0;
    localparam int IRQ_WAKE  = 1;
    localparam int NUM_IRQ   = 2;

    mode_req_t          req;
    tx_pend_t           pend;
    mode_e              target, mode;
    logic               sleep_block, enter_sleep, bus_wake;
    logic [NUM_IRQ-1:0] irq_set, irq_clr, irq_flag;

    assign req  = '{enable: ctl_enable, sleep: ctl_sleep_req,
                    loopback: ctl_loop_req, snoop: ctl_snoop_req};
    assign pend = '{hpb: hpb_pending, txq: txq_pending};

    can_mode_decode u_decode (
        .req         (req),
        .sleep_block (sleep_block),
        .target      (target)
    );

    can_mode_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .target      (target),
        .sleep_req   (ctl_sleep_req),
        .bus_idle    (bus_idle),
        .rx_sof      (rx_sof),
        .mode        (mode),
        .sleep_block (sleep_block),
        .enter_sleep (enter_sleep),
        .bus_wake    (bus_wake)
    );

    can_mode_paths #(.RECESSIVE(RECESSIVE)) u_paths (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .pend         (pend),
        .core_tx_bit  (core_tx_bit),
        .pin_rx       (pin_rx),
        .pin_tx       (pin_tx),
        .core_rx_bit  (core_rx_bit),
        .self_ack     (self_ack),
        .grant_hpb    (grant_hpb),
        .grant_txq    (grant_txq),
        .err_cnt_clr  (err_cnt_clr),
        .timing_wr_en (timing_wr_en)
    );

    always_comb begin
        irq_set            = '0;
        irq_clr            = '0;
        irq_set[IRQ_SLEEP] = enter_sleep;
        irq_set[IRQ_WAKE]  = bus_wake;
        irq_clr[IRQ_SLEEP] = irq_sleep_clr;
        irq_clr[IRQ_WAKE]  = irq_wake_clr;
    end

    can_mode_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  (irq_set),
        .clr  (irq_clr),
        .flag (irq_flag)
    );

    assign mode_status = mode_onehot(mode);
    assign irq_sleep   = irq_flag[IRQ_SLEEP];
    assign irq_wake    = irq_flag[IRQ_WAKE];

    // R1
    status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(mode_status) == 1);

    // R5
    cfg_no_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_enable && !irq_wake) |=> !irq_wake);

endmodule

// File: tb/can_mode_ctrl_tb.sv
module can_mode_ctrl_tb;

    localparam logic [4:0] M_CFG    = 5'b00001;
    localparam logic [4:0] M_NORMAL = 5'b00010;
    localparam logic [4:0] M_SLEEP  = 5'b00100;
    localparam logic [4:0] M_LOOP   = 5'b01000;
    localparam logic [4:0] M_SNOOP  = 5'b10000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_enable = 0, ctl_sleep_req = 0, ctl_loop_req = 0, ctl_snoop_req = 0;
    logic bus_idle = 0, rx_sof = 0, txq_pending = 0, hpb_pending = 0;
    logic irq_sleep_clr = 0, irq_wake_clr = 0, core_tx_bit = 1, pin_rx = 1;
    logic pin_tx, core_rx_bit, self_ack, grant_hpb, grant_txq, err_cnt_clr, timing_wr_en;
    logic [4:0] mode_status;
    logic irq_sleep, irq_wake;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    can_mode_ctrl u_dut (
        .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .ctl_sleep_req(ctl_sleep_req),
        .ctl_loop_req(ctl_loop_req), .ctl_snoop_req(ctl_snoop_req), .bus_idle(bus_idle),
        .rx_sof(rx_sof), .txq_pending(txq_pending), .hpb_pending(hpb_pending),
        .irq_sleep_clr(irq_sleep_clr), .irq_wake_clr(irq_wake_clr),
        .core_tx_bit(core_tx_bit), .pin_rx(pin_rx), .pin_tx(pin_tx),
        .core_rx_bit(core_rx_bit), .self_ack(self_ack), .grant_hpb(grant_hpb),
        .grant_txq(grant_txq), .err_cnt_clr(err_cnt_clr), .timing_wr_en(timing_wr_en),
        .mode_status(mode_status), .irq_sleep(irq_sleep), .irq_wake(irq_wake)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        step();
        chk("R1 reset mode", 8'(mode_status), 8'(M_CFG));
        chk("R1 reset irqs", {6'd0, irq_sleep, irq_wake}, 8'h00);
    endtask

    task automatic t_cfg_quiet();
        txq_pending = 1; hpb_pending = 1; core_tx_bit = 0; pin_rx = 0;
        settle();
        chk("R2 cfg pin_tx", 8'(pin_tx), 8'h01);
        chk("R2 cfg grants", {6'd0, grant_hpb, grant_txq}, 8'h00);
        chk("R2 cfg rx bit", 8'(core_rx_bit), 8'h01);
        chk("R2 cfg clr/twr", {6'd0, err_cnt_clr, timing_wr_en}, 8'h03);
        txq_pending = 0; hpb_pending = 0;
    endtask

    task automatic t_leave_cfg();
        ctl_enable = 1; bus_idle = 0;
        step();
        chk("R4 wait idle leaving cfg", 8'(mode_status), 8'(M_CFG));
        bus_idle = 1;
        step();
        chk("R4 normal at idle", 8'(mode_status), 8'(M_NORMAL));
        chk("R2 normal clr/twr low", {6'd0, err_cnt_clr, timing_wr_en}, 8'h00);
    endtask

    task automatic t_normal_paths();
        core_tx_bit = 0; pin_rx = 1; txq_pending = 1; hpb_pending = 0;
        settle();
        chk("R6 pin_tx follows tx 0", 8'(pin_tx), 8'h00);
        chk("R6 rx follows pin 1", 8'(core_rx_bit), 8'h01);
        chk("R6 txq grant", {6'd0, grant_hpb, grant_txq}, 8'h01);
        core_tx_bit = 1; pin_rx = 0;
        settle();
        chk("R6 pin_tx follows tx 1", 8'(pin_tx), 8'h01);
        chk("R6 rx follows pin 0", 8'(core_rx_bit), 8'h00);
        hpb_pending = 1;
        settle();
        chk("R7 hpb over txq", {6'd0, grant_hpb, grant_txq}, 8'h02);
        txq_pending = 0; hpb_pending = 0;
    endtask

    task automatic t_sleep_wake();
        ctl_sleep_req = 1; ctl_loop_req = 1; ctl_snoop_req = 1; bus_idle = 1;
        step();
        chk("R3 sleep wins", 8'(mode_status), 8'(M_SLEEP));
        chk("R10 sleep irq set", 8'(irq_sleep), 8'h01);
        txq_pending = 1; hpb_pending = 1; core_tx_bit = 0; pin_rx = 0;
        settle();
        chk("R8 sleep no grants", {6'd0, grant_hpb, grant_txq}, 8'h00);
        chk("R8 sleep pin recessive", 8'(pin_tx), 8'h01);
        chk("R8 sleep rx follows pin", 8'(core_rx_bit), 8'h00);
        step();
        chk("R8 stays asleep with pending", 8'(mode_status), 8'(M_SLEEP));
        txq_pending = 0; hpb_pending = 0; pin_rx = 1;
        bus_idle = 0; rx_sof = 1;
        step();
        rx_sof = 0;
        chk("R9 wake to normal", 8'(mode_status), 8'(M_NORMAL));
        chk("R10 wake irq set", 8'(irq_wake), 8'h01);
        ctl_loop_req = 0; ctl_snoop_req = 0; bus_idle = 1;
        step(); step();
        chk("R9 sleep req ignored after wake", 8'(mode_status), 8'(M_NORMAL));
        ctl_sleep_req = 0;
        step();
        ctl_sleep_req = 1;
        step();
        chk("R9 sleep again after rewrite", 8'(mode_status), 8'(M_SLEEP));
        ctl_sleep_req = 0; ctl_loop_req = 1;
        step();
        chk("R3 loop from sleep", 8'(mode_status), 8'(M_LOOP));
    endtask

    task automatic t_loop_snoop();
        core_tx_bit = 0; pin_rx = 1; hpb_pending = 1;
        settle();
        chk("R11 loop pin recessive", 8'(pin_tx), 8'h01);
        chk("R11 loop rx from tx 0", 8'(core_rx_bit), 8'h00);
        chk("R11 loop self ack and grant", {6'd0, self_ack, grant_hpb}, 8'h03);
        core_tx_bit = 1; pin_rx = 0;
        settle();
        chk("R11 loop rx from tx 1", 8'(core_rx_bit), 8'h01);
        ctl_loop_req = 0; ctl_snoop_req = 1; core_tx_bit = 0; txq_pending = 1;
        step();
        chk("R3 snoop selected", 8'(mode_status), 8'(M_SNOOP));
        chk("R12 snoop pin recessive", 8'(pin_tx), 8'h01);
        chk("R12 snoop no grants", {6'd0, grant_hpb, grant_txq}, 8'h00);
        chk("R12 snoop rx from pin", {6'd0, self_ack, core_rx_bit}, 8'h00);
        ctl_loop_req = 1;
        step();
        chk("R3 loop over snoop", 8'(mode_status), 8'(M_LOOP));
        ctl_loop_req = 0; ctl_snoop_req = 0; hpb_pending = 0; txq_pending = 0;
        step();
        chk("R3 plain normal", 8'(mode_status), 8'(M_NORMAL));
    endtask

    task automatic t_defer();
        bus_idle = 0; ctl_snoop_req = 1;
        step(); step();
        chk("R4 held while busy", 8'(mode_status), 8'(M_NORMAL));
        bus_idle = 1;
        step();
        chk("R4 taken at idle", 8'(mode_status), 8'(M_SNOOP));
    endtask

    task automatic t_cfg_drop_and_clear();
        bus_idle = 0; ctl_enable = 0;
        step();
        chk("R5 cfg while busy", 8'(mode_status), 8'(M_CFG));
        irq_sleep_clr = 1;
        step();
        irq_sleep_clr = 0;
        chk("R10 sleep cleared, wake kept", {6'd0, irq_sleep, irq_wake}, 8'h01);
        step();
        chk("R10 sleep stays clear", 8'(irq_sleep), 8'h00);
        irq_wake_clr = 1;
        step();
        irq_wake_clr = 0;
        chk("R10 wake cleared", 8'(irq_wake), 8'h00);
        ctl_snoop_req = 0; ctl_enable = 1; ctl_sleep_req = 1; bus_idle = 1;
        step();
        chk("R4 cfg to sleep", 8'(mode_status), 8'(M_SLEEP));
        ctl_enable = 0; rx_sof = 1; bus_idle = 0;
        step();
        rx_sof = 0;
        chk("R5 cfg beats wake", 8'(mode_status), 8'(M_CFG));
        chk("R5 no wake flag", 8'(irq_wake), 8'h00);
    endtask

    initial begin
        t_reset();
        t_cfg_quiet();
        t_leave_cfg();
        t_normal_paths();
        t_sleep_wake();
        t_loop_snoop();
        t_defer();
        t_cfg_drop_and_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule